// File: doc/BRIEF.md
# Centered Binomial Noise Sampler

This block turns a fixed-length stream of random bytes into one polynomial of 256 small-noise coefficients modulo 3329. It draws them from a centered binomial distribution whose width eta is picked at run time. For every coefficient the block takes 2·eta consecutive stream bits. It counts the ones in the first eta bits and in the second eta bits, and it emits the difference. A negative difference is wrapped into the range of the modulus.

Bytes arrive as 32-bit words on a ready/valid sink. A bit gearbox feeds a single popcount datapath, which serves both eta settings and consumes 16 or 24 bits for each output beat. Each beat carries four 12-bit coefficients. Beats leave through a two-entry queue that honours ready/valid back-pressure on the source side. The last beat of each polynomial is flagged. The producer of the random bytes sits upstream and is not part of the block.

Top module: `cbd_sampler`

## Requirements
- R1: After a synchronous active-low reset, `m_axis_tvalid` is low, `s_axis_tready` is high, and any partly received frame is discarded.
- R2: With `is_eta3` high each coefficient uses 6 stream bits (eta=3), and with it low each uses 4 bits (eta=2). `is_eta3` is held constant for the whole of a frame.
- R3: Stream bit j is bit j mod 32 of sink word j/32. Byte k of a word occupies bits 8k+7..8k, so bits are taken least-significant first within each byte and bytes are taken in stream order.
- R4: Coefficient i equals popcount(x) − popcount(y). Here x is stream bits [2·eta·i, 2·eta·i+eta) and y is the eta bits that follow. A negative result d is output as 3329+d.
- R5: Every coefficient on the source is one of 0, 1, 2, 3, 3326, 3327 or 3328.
- R6: A beat carries coefficient 4b+k of beat b in `m_axis_tdata` bits 12k+11..12k, for k = 0..3.
- R7: `m_axis_tlast` is high on the 64th beat of each frame and low on all other beats.
- R8: While `m_axis_tvalid` is high and `m_axis_tready` is low, `m_axis_tvalid`, `m_axis_tdata` and `m_axis_tlast` hold their values.
- R9: A frame consumes exactly 32 sink words (128 bytes) for eta=2 and 48 words (192 bytes) for eta=3. Once a frame ends no output remains pending, and the next frame starts cleanly.
- R10: When the source is stalled, the two-entry output queue and the 64-bit gearbox fill up, and `s_axis_tready` then drops. No input is lost, and all beats come out correct after the stall ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| is_eta3 | input | 1 | High selects eta=3, low selects eta=2 |
| s_axis_tdata | input | 32 | Random stream word, byte 0 in the low bits |
| s_axis_tvalid | input | 1 | Sink word valid |
| s_axis_tready | output | 1 | Sink can accept a word |
| m_axis_tdata | output | 48 | Four packed 12-bit coefficients |
| m_axis_tvalid | output | 1 | Source beat valid |
| m_axis_tready | input | 1 | Downstream accepts the beat |
| m_axis_tlast | output | 1 | Last beat of the polynomial |

## Verification
The bench targets the wrap of negative differences: a design that drops the modulus add or wraps by the wrong amount puts values such as 4095 or 3325 on the bus. It targets the eta=3 groups that straddle word and byte boundaries, where a gearbox that shifts by the wrong count or reads bytes in reverse order scrambles every coefficient after the first word. Frames are run with random stalls on both sides and with a long source stall. A queue that overwrites a waiting entry, or a payload that changes under a low ready, shows up as lost or altered beats. The bench also checks that tlast lands only on beat 64 and that nothing is left over between frames, which would shift the next polynomial.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
  localparam int unsigned Q_MOD   = 3329;
  localparam int unsigned COEF_W  = 12;
  localparam int unsigned ETA_MAX = 3;
  localparam int unsigned GRP_W   = 2 * ETA_MAX;       // bits per coefficient, eta=3
  localparam int unsigned GRP2_W  = 2 * (ETA_MAX - 1); // bits per coefficient, eta=2

  // ones in a 3-bit field
  function automatic logic [1:0] ones3(input logic [2:0] v);
    return {1'b0, v[0]} + {1'b0, v[1]} + {1'b0, v[2]};
  endfunction

  // one binomial coefficient from a group of stream bits, reduced mod Q_MOD
  function automatic logic [COEF_W-1:0] cbd_coef(input logic [GRP_W-1:0] grp,
                                                 input logic eta3);
    logic [1:0] a, b;
    a = eta3 ? ones3(grp[2:0]) : ones3({1'b0, grp[1:0]});
    b = eta3 ? ones3(grp[5:3]) : ones3({1'b0, grp[3:2]});
    if (a >= b) return COEF_W'(a - b);
    return COEF_W'(Q_MOD) - COEF_W'(b - a);
  endfunction
endpackage

// File: rtl/cbd_gearbox.sv
module cbd_gearbox #(
  parameter int IN_W     = 32,
  parameter int BUF_W    = 2 * IN_W,
  parameter int TAKE_MAX = 24,
  localparam int CNT_W   = $clog2(BUF_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IN_W-1:0]     s_data,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [CNT_W-1:0]    need,
  input  logic                pop,
  output logic                have,
  output logic [TAKE_MAX-1:0] window,
  output logic [CNT_W-1:0]    fill
);
  logic [BUF_W-1:0] bits_q, shifted, merged;
  logic [CNT_W-1:0] fill_q, left, fill_d;
  logic             push;

  assign s_ready = fill_q <= CNT_W'(BUF_W - IN_W);
  assign push    = s_valid && s_ready;
  assign have    = fill_q >= need;
  assign window  = bits_q[TAKE_MAX-1:0];
  assign fill    = fill_q;

  always_comb begin
    shifted = pop ? (bits_q >> need) : bits_q;
    left    = pop ? (fill_q - need) : fill_q;
    merged  = shifted;
    fill_d  = left;
    if (push) begin
      merged = shifted | ({{(BUF_W-IN_W){1'b0}}, s_data} << left);
      fill_d = left + CNT_W'(IN_W);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_q <= '0;
      fill_q <= '0;
    end else begin
      bits_q <= merged;
      fill_q <= fill_d;
    end
  end
endmodule

// File: rtl/cbd_lanes.sv
module cbd_lanes
  import cbd_pkg::*;
#(
  parameter int LANES = 4,
  localparam int WIN_W = LANES * GRP_W
) (
  input  logic [WIN_W-1:0]        window,
  input  logic                    eta3,
  output logic [LANES*COEF_W-1:0] coefs
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [GRP_W-1:0] grp;
    assign grp = eta3 ? window[GRP_W*k +: GRP_W]
                      : {{(GRP_W-GRP2_W){1'b0}}, window[GRP2_W*k +: GRP2_W]};
    assign coefs[COEF_W*k +: COEF_W] = cbd_coef(grp, eta3);
  end
endmodule

// File: rtl/cbd_skid.sv
module cbd_skid #(
  parameter int W     = 49,
  parameter int DEPTH = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  output logic          room,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  input  logic          out_ready,
  output logic [LW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [LW-1:0] cnt_q;
  logic          wr, rd;

  assign room      = cnt_q < LW'(DEPTH);
  assign out_valid = cnt_q != '0;
  assign out_data  = mem[rd_q];
  assign level     = cnt_q;
  assign wr        = in_valid && room;
  assign rd        = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (wr) mem[wr_q] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr) wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (rd) rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + LW'(wr) - LW'(rd);
    end
  end
endmodule

// File: rtl/cbd_sampler.sv
module cbd_sampler
  import cbd_pkg::*;
#(
  parameter int IN_W   = 32,
  parameter int LANES  = 4,
  parameter int N_COEF = 256,
  parameter int QDEPTH = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    is_eta3,
  input  logic [IN_W-1:0]         s_axis_tdata,
  input  logic                    s_axis_tvalid,
  output logic                    s_axis_tready,
  output logic [LANES*COEF_W-1:0] m_axis_tdata,
  output logic                    m_axis_tvalid,
  input  logic                    m_axis_tready,
  output logic                    m_axis_tlast
);
  localparam int BUF_W    = 2 * IN_W;
  localparam int TAKE_MAX = LANES * GRP_W;
  localparam int CNT_W    = $clog2(BUF_W + 1);
  localparam int BEATS    = N_COEF / LANES;
  localparam int BEAT_W   = $clog2(BEATS);
  localparam int OUT_W    = LANES * COEF_W;
  localparam int QL_W     = $clog2(QDEPTH + 1);

  logic [CNT_W-1:0]    need, gear_fill;
  logic [TAKE_MAX-1:0] window;
  logic                have, q_room, beat_fire, beat_last;
  logic [OUT_W-1:0]    coefs;
  logic [BEAT_W-1:0]   beat_idx;
  logic [QL_W-1:0]     q_level;

  assign need      = is_eta3 ? CNT_W'(LANES * GRP_W) : CNT_W'(LANES * GRP2_W);
  assign beat_fire = have && q_room;
  assign beat_last = beat_idx == BEAT_W'(BEATS - 1);

  cbd_gearbox #(.IN_W(IN_W), .BUF_W(BUF_W), .TAKE_MAX(TAKE_MAX)) u_gear (
    .clk(clk), .rst_n(rst_n),
    .s_data(s_axis_tdata), .s_valid(s_axis_tvalid), .s_ready(s_axis_tready),
    .need(need), .pop(beat_fire), .have(have), .window(window), .fill(gear_fill)
  );

  cbd_lanes #(.LANES(LANES)) u_lanes (
    .window(window), .eta3(is_eta3), .coefs(coefs)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         beat_idx <= '0;
    else if (beat_fire) beat_idx <= beat_last ? '0 : beat_idx + 1'b1;
  end

  cbd_skid #(.W(OUT_W + 1), .DEPTH(QDEPTH)) u_skid (
    .clk(clk), .rst_n(rst_n),
    .in_valid(beat_fire), .in_data({beat_last, coefs}), .room(q_room),
    .out_valid(m_axis_tvalid), .out_data({m_axis_tlast, m_axis_tdata}),
    .out_ready(m_axis_tready), .level(q_level)
  );
endmodule

// File: rtl/cbd_sampler_chk.sv
module cbd_sampler_chk #(
  parameter int LANES  = 4,
  parameter int COEF_W = 12,
  parameter int CNT_W  = 7,
  parameter int BUF_W  = 64,
  parameter int QL_W   = 2,
  parameter int QDEPTH = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    m_valid,
  input logic                    m_ready,
  input logic                    m_last,
  input logic [LANES*COEF_W-1:0] m_data,
  input logic [QL_W-1:0]         q_level,
  input logic [CNT_W-1:0]        gear_fill
);
  function automatic logic legal_beat(input logic [LANES*COEF_W-1:0] d);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k < LANES; k++) begin
      if (!(d[COEF_W*k +: COEF_W] <= COEF_W'(3) ||
            (d[COEF_W*k +: COEF_W] >= COEF_W'(3326) &&
             d[COEF_W*k +: COEF_W] <= COEF_W'(3328))))
        ok = 1'b0;
    end
    return ok;
  endfunction

  a_r5_value_set: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> legal_beat(m_data));

  a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  a_r10_queue_bound: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= QL_W'(QDEPTH));

  a_r10_gear_bound: assert property (@(posedge clk) disable iff (!rst_n)
    gear_fill <= CNT_W'(BUF_W));
endmodule

bind cbd_sampler cbd_sampler_chk #(
  .LANES(LANES), .COEF_W(cbd_pkg::COEF_W), .CNT_W(CNT_W),
  .BUF_W(BUF_W), .QL_W(QL_W), .QDEPTH(QDEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .m_valid(m_axis_tvalid), .m_ready(m_axis_tready), .m_last(m_axis_tlast),
  .m_data(m_axis_tdata), .q_level(q_level), .gear_fill(gear_fill)
);

// File: tb/cbd_sampler_bench.sv
module cbd_sampler_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCOEF = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        is_eta3 = 1'b0;
  logic [31:0] s_data = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [47:0] m_data;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic        m_last;

  int n_checks = 0;
  int n_fail = 0;

  logic [1535:0] fbits;
  logic [11:0]   expc [NCOEF];

  // {eta3, group pattern (low bits first), expected coefficient}
  localparam logic [18:0] VEC [14] = '{
    {1'b0, 6'b000000, 12'd0},    {1'b0, 6'b000011, 12'd2},
    {1'b0, 6'b001100, 12'd3327}, {1'b0, 6'b000101, 12'd0},
    {1'b0, 6'b001110, 12'd3328}, {1'b0, 6'b000111, 12'd1},
    {1'b0, 6'b001000, 12'd3328}, {1'b1, 6'b000111, 12'd3},
    {1'b1, 6'b111000, 12'd3326}, {1'b1, 6'b111111, 12'd0},
    {1'b1, 6'b011111, 12'd1},    {1'b1, 6'b110001, 12'd3328},
    {1'b1, 6'b100000, 12'd3328}, {1'b1, 6'b111100, 12'd3327}
  };

  cbd_sampler u_cbd_sampler (
    .clk(clk), .rst_n(rst_n), .is_eta3(is_eta3),
    .s_axis_tdata(s_data), .s_axis_tvalid(s_valid), .s_axis_tready(s_ready),
    .m_axis_tdata(m_data), .m_axis_tvalid(m_valid), .m_axis_tready(m_ready),
    .m_axis_tlast(m_last)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // independent reference: count ones bit by bit (R4, R3)
  function automatic logic [11:0] model(input int i, input bit e3);
    int e, x, y, d;
    e = e3 ? 3 : 2; x = 0; y = 0;
    for (int j = 0; j < e; j++) begin
      x += int'(fbits[2*e*i + j]);
      y += int'(fbits[2*e*i + e + j]);
    end
    d = x - y;
    return (d < 0) ? 12'(3329 + d) : 12'(d);
  endfunction

  task automatic drive(input bit e3, input int mode);
    int nw;
    bit acc;
    nw = e3 ? 48 : 32;
    for (int w = 0; w < nw; w++) begin
      if (mode == 1 && $urandom_range(0, 3) == 0) begin
        s_valid = 1'b0;
        @(negedge clk);
      end
      s_valid = 1'b1;
      s_data  = fbits[32*w +: 32];
      do begin
        acc = s_ready;
        @(negedge clk);
      end while (!acc);
    end
    s_valid = 1'b0;
  endtask

  task automatic consume(input int mode, input string tag);
    int b;
    bit pend;
    logic [47:0] hd, expb;
    logic hl;
    b = 0; pend = 1'b0; hd = '0; hl = 1'b0;
    if (mode == 2) begin
      m_ready = 1'b0;
      repeat (30) @(negedge clk);
      chk(s_ready == 1'b0, "R10 sink stalls", 64'(s_ready), 64'd0);
      chk(m_valid == 1'b1, "R10 queue holds", 64'(m_valid), 64'd1);
    end
    while (b < 64) begin
      @(negedge clk);
      if (pend) chk(m_valid && m_data == hd && m_last == hl, "R8 hold",
                    {15'd0, m_valid, m_data}, {16'd1, hd});
      m_ready = (mode == 1) ? 1'($urandom_range(0, 1)) : 1'b1;
      if (m_valid && m_ready) begin
        expb = {expc[4*b+3], expc[4*b+2], expc[4*b+1], expc[4*b]};
        chk(m_data == expb, tag, 64'(m_data), 64'(expb));
        chk(m_last == (b == 63), "R7 tlast", 64'(m_last), 64'(b == 63));
        b++;
        pend = 1'b0;
      end else begin
        pend = m_valid; hd = m_data; hl = m_last;
      end
    end
    @(negedge clk);
    m_ready = 1'b0;
  endtask

  task automatic run_frame(input bit e3, input int mode, input string tag);
    @(negedge clk);
    is_eta3 = e3;
    fork
      drive(e3, mode);
      consume(mode, tag);
    join
    repeat (4) @(negedge clk);
    chk(m_valid == 1'b0, "R9 nothing left after frame", 64'(m_valid), 64'd0);
    chk(s_ready == 1'b1, "R9 sink idle after frame", 64'(s_ready), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(m_valid == 1'b0, "R1 valid after reset", 64'(m_valid), 64'd0);
    chk(s_ready == 1'b1, "R1 ready after reset", 64'(s_ready), 64'd1);

    // table walk: one pattern repeated over a whole frame (R2, R4, R5)
    for (int v = 0; v < 14; v++) begin
      fbits = '0;
      for (int i = 0; i < NCOEF; i++) begin
        if (VEC[v][18]) fbits[6*i +: 6] = VEC[v][17:12];
        else            fbits[4*i +: 4] = VEC[v][15:12];
        expc[i] = VEC[v][11:0];
      end
      run_frame(VEC[v][18], 0, "R4 table coefficient (R2 R5)");
    end

    // random frames with model, both eta, with and without stalls (R3, R6)
    for (int f = 0; f < 6; f++) begin
      bit e3;
      e3 = f[0];
      for (int w = 0; w < 48; w++) fbits[32*w +: 32] = $urandom;
      for (int i = 0; i < NCOEF; i++) expc[i] = model(i, e3);
      run_frame(e3, (f >= 2) ? 1 : 0, "R3 R6 random frame");
    end

    // long source stall (R10) for both eta
    for (int f = 0; f < 2; f++) begin
      for (int w = 0; w < 48; w++) fbits[32*w +: 32] = $urandom;
      for (int i = 0; i < NCOEF; i++) expc[i] = model(i, f[0]);
      run_frame(f[0], 2, "R10 data after stall");
    end

    // reset mid-frame discards partial input (R1)
    @(negedge clk);
    is_eta3 = 1'b1;
    for (int w = 0; w < 3; w++) begin
      s_valid = 1'b1; s_data = $urandom;
      @(negedge clk);
    end
    s_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_valid == 1'b0, "R1 valid after mid-frame reset", 64'(m_valid), 64'd0);
    chk(s_ready == 1'b1, "R1 ready after mid-frame reset", 64'(s_ready), 64'd1);
    for (int w = 0; w < 48; w++) fbits[32*w +: 32] = $urandom;
    for (int i = 0; i < NCOEF; i++) expc[i] = model(i, 1'b0);
    run_frame(1'b0, 0, "R1 clean frame after reset");

    summary();
  end
endmodule